// File: doc/BRIEF.md
# Four-Bit Hex and Decimal Digit ALU

This block is the arithmetic heart of a digit-serial calculator datapath. Each step of a microprogram presents two 4-bit digit operands, a carry or borrow bit left over from the previous digit, and a 3-bit function code taken directly from a field of the microinstruction. The ALU responds in the same cycle with a 4-bit digit result and a carry or borrow output. There are no registers inside: operand selection and the flag register that holds the carry between digits belong to the surrounding datapath.

The eight function codes cover three kinds of operation. Four codes are non-arithmetic: clear, pass either operand, and bitwise XOR. The other four are digit arithmetic: add with carry and subtract with borrow, each in either plain binary (hex) or decimal (BCD) form. The decimal forms apply the usual six-step correction so that a chain of digits behaves as decimal arithmetic. A small decoder turns the code into a struct of strobes, and the datapath computes both raw lanes and their decimal corrections in parallel before a final select.

Top module: `digit_alu`

## Requirements
- R1: Function code 3'b000 drives result 4'h0 and carryOut 0 for every operand and carryIn value.
- R2: Function code 3'b001 drives result equal to opS; code 3'b010 drives result equal to opR; carryOut is 0 for both.
- R3: Function code 3'b011 drives result equal to opS XOR opR, with carryOut 0.
- R4: Function code 3'b100 drives {carryOut, result} equal to the 5-bit sum opS + opR + carryIn.
- R5: Function code 3'b101 forms t = opS + opR + carryIn; when t > 9 result is the low 4 bits of t + 6 and carryOut is 1, otherwise result is t and carryOut is 0.
- R6: Function code 3'b110 drives result equal to (opS - opR - carryIn) mod 16, with carryOut 1 exactly when opS < opR + carryIn.
- R7: Function code 3'b111 forms d = opS - opR - carryIn; when d is negative result is (d - 6) mod 16 and carryOut is 1, otherwise result is d and carryOut is 0.
- R8: For codes 3'b000 to 3'b011 the carryIn input has no effect on result and carryOut stays 0.
- R9: For codes 3'b101 and 3'b111 with both operands in 0..9, result is a decimal digit in 0..9 and the pair {carryOut, result} equals the correct decimal digit sum or difference with carry or borrow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opS | input | 4 | First digit operand |
| opR | input | 4 | Second digit operand (subtrahend in subtraction) |
| carryIn | input | 1 | Carry into addition or borrow into subtraction |
| funcSel | input | 3 | Function code from the microinstruction |
| result | output | 4 | Digit result |
| carryOut | output | 1 | Carry out of addition or borrow out of subtraction, 0 otherwise |

## Verification
Every function code is driven with all 256 operand pairs under both carryIn values, so each code is tried against the full input space rather than a sample. The exhaustive arithmetic sweeps separate the hex and decimal forms at exactly the digit sums above 9 and the negative differences, where the two corrections diverge, and the carryIn half of the sweep tells a correct carry chain from one that drops the incoming carry or borrow. Dedicated corner cases (9+9+1, 0-0-1, 0-9, F+F+1) pin the extremes of the correction, and repeating the non-arithmetic codes with carryIn toggled shows that carry has no reach into them.

// File: rtl/digit_alu_pkg.sv
package digit_alu_pkg;

  localparam int DIGIT_W = 4;
  localparam int FUNC_W  = 3;
  localparam int RAW_W   = DIGIT_W + 1;
  localparam int DEC_MAX = 9;
  localparam int DEC_ADJ = 6;
  localparam int LANES   = 2;   // lane 0 adds, lane 1 subtracts

  typedef enum logic [FUNC_W-1:0] {
    FN_ZERO   = 3'b000,
    FN_PASS_S = 3'b001,
    FN_PASS_R = 3'b010,
    FN_XOR    = 3'b011,
    FN_ADD_HX = 3'b100,
    FN_ADD_DC = 3'b101,
    FN_SUB_HX = 3'b110,
    FN_SUB_DC = 3'b111
  } aluFunc_e;

  typedef struct packed {
    logic selS;
    logic selR;
    logic selXor;
    logic arith;
    logic subtract;
    logic decimal;
  } aluStrobes_t;

endpackage

// File: rtl/digit_alu_ctrl.sv
module digit_alu_ctrl
  import digit_alu_pkg::*;
(
  input  logic [FUNC_W-1:0] funcSel,
  output aluStrobes_t       strobes
);

  aluFunc_e fn;

  assign fn = aluFunc_e'(funcSel);

  always_comb begin
    strobes = '0;
    case (fn)
      FN_ZERO:   strobes = '0;
      FN_PASS_S: strobes.selS = 1'b1;
      FN_PASS_R: strobes.selR = 1'b1;
      FN_XOR:    strobes.selXor = 1'b1;
      FN_ADD_HX: strobes.arith = 1'b1;
      FN_ADD_DC: begin
        strobes.arith   = 1'b1;
        strobes.decimal = 1'b1;
      end
      FN_SUB_HX: begin
        strobes.arith    = 1'b1;
        strobes.subtract = 1'b1;
      end
      FN_SUB_DC: begin
        strobes.arith    = 1'b1;
        strobes.subtract = 1'b1;
        strobes.decimal  = 1'b1;
      end
      default:   strobes = '0;
    endcase
  end

endmodule

// File: rtl/digit_alu_dec_adjust.sv
module digit_alu_dec_adjust
  import digit_alu_pkg::*;
#(
  parameter bit IS_SUB = 1'b0
)(
  input  logic [RAW_W-1:0]   rawVal,
  output logic [DIGIT_W-1:0] adjDigit,
  output logic               adjFlag
);

  logic [RAW_W-1:0] corrected;

  generate
    if (IS_SUB) begin : g_sub
      // a borrow shows as the top bit of the raw difference
      assign adjFlag   = rawVal[RAW_W-1];
      assign corrected = rawVal - RAW_W'(DEC_ADJ);
    end else begin : g_add
      assign adjFlag   = (rawVal > RAW_W'(DEC_MAX));
      assign corrected = rawVal + RAW_W'(DEC_ADJ);
    end
  endgenerate

  assign adjDigit = adjFlag ? corrected[DIGIT_W-1:0] : rawVal[DIGIT_W-1:0];

endmodule

// File: rtl/digit_alu_dp.sv
module digit_alu_dp
  import digit_alu_pkg::*;
(
  input  logic [DIGIT_W-1:0] opS,
  input  logic [DIGIT_W-1:0] opR,
  input  logic               carryIn,
  input  aluStrobes_t        strobes,
  output logic [DIGIT_W-1:0] result,
  output logic               carryOut
);

  logic [RAW_W-1:0]   rawLane  [LANES];
  logic [DIGIT_W-1:0] adjDigit [LANES];
  logic               adjFlag  [LANES];
  logic [RAW_W-1:0]   extS, extR, extC;

  assign extS = {1'b0, opS};
  assign extR = {1'b0, opR};
  assign extC = RAW_W'(carryIn);

  assign rawLane[0] = extS + extR + extC;
  assign rawLane[1] = extS - extR - extC;

  generate
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      digit_alu_dec_adjust #(.IS_SUB(ln == 1)) u_adj (
        .rawVal   (rawLane[ln]),
        .adjDigit (adjDigit[ln]),
        .adjFlag  (adjFlag[ln])
      );
    end
  endgenerate

  always_comb begin
    result   = '0;
    carryOut = 1'b0;
    if (strobes.arith) begin
      if (strobes.decimal) begin
        result   = adjDigit[strobes.subtract];
        carryOut = adjFlag[strobes.subtract];
      end else begin
        result   = rawLane[strobes.subtract][DIGIT_W-1:0];
        carryOut = rawLane[strobes.subtract][RAW_W-1];
      end
    end else if (strobes.selS) begin
      result = opS;
    end else if (strobes.selR) begin
      result = opR;
    end else if (strobes.selXor) begin
      result = opS ^ opR;
    end
  end

endmodule

// File: rtl/digit_alu.sv
module digit_alu
  import digit_alu_pkg::*;
(
  input  logic [3:0] opS,
  input  logic [3:0] opR,
  input  logic       carryIn,
  input  logic [2:0] funcSel,
  output logic [3:0] result,
  output logic       carryOut
);

  aluStrobes_t strobes;

  digit_alu_ctrl u_ctrl (
    .funcSel (funcSel),
    .strobes (strobes)
  );

  digit_alu_dp u_dp (
    .opS      (opS),
    .opR      (opR),
    .carryIn  (carryIn),
    .strobes  (strobes),
    .result   (result),
    .carryOut (carryOut)
  );

endmodule

// File: rtl/digit_alu_chk.sv
module digit_alu_chk (
  input logic [3:0] opS,
  input logic [3:0] opR,
  input logic       carryIn,
  input logic [2:0] funcSel,
  input logic [3:0] result,
  input logic       carryOut
);

  logic [4:0] hexSum;
  logic       validDigits;

  assign hexSum      = {1'b0, opS} + {1'b0, opR} + {4'b0, carryIn};
  assign validDigits = (opS <= 4'd9) && (opR <= 4'd9);

  always_comb begin
    // R1
    zero_result_chk: assert (funcSel != 3'b000 || result == 4'h0);
    // R2
    pass_s_chk: assert (funcSel != 3'b001 || result == opS);
    // R2
    pass_r_chk: assert (funcSel != 3'b010 || result == opR);
    // R3
    xor_result_chk: assert (funcSel != 3'b011 || result == (opS ^ opR));
    // R4
    hex_sum_chk: assert (funcSel != 3'b100 || {carryOut, result} == hexSum);
    // R8
    logic_no_carry_chk: assert (funcSel[2] || !carryOut);
    // R9
    dec_digit_range_chk: assert (!(funcSel[2] && funcSel[0] && validDigits) || result <= 4'd9);
  end

endmodule

bind digit_alu digit_alu_chk u_chk (
  .opS      (opS),
  .opR      (opR),
  .carryIn  (carryIn),
  .funcSel  (funcSel),
  .result   (result),
  .carryOut (carryOut)
);

// File: tb/digit_alu_tb.sv
`timescale 1ns/1ps
module digit_alu_tb;

  logic       clk = 1'b0;
  logic [3:0] opS = '0;
  logic [3:0] opR = '0;
  logic       carryIn = 1'b0;
  logic [2:0] funcSel = '0;
  logic [3:0] result;
  logic       carryOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  digit_alu u_dut (
    .opS      (opS),
    .opR      (opR),
    .carryIn  (carryIn),
    .funcSel  (funcSel),
    .result   (result),
    .carryOut (carryOut)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic apply(input logic [2:0] f, input int s, input int r, input logic c);
    @(negedge clk);
    funcSel = f;
    opS     = 4'(s);
    opR     = 4'(r);
    carryIn = c;
    #2;
  endtask

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s f=%b s=%0d r=%0d c=%0d got={%b,%h} exp={%b,%h}",
               req, funcSel, opS, opR, carryIn, got[4], got[3:0], exp[4], exp[3:0]);
    end
  endtask

  function automatic logic [4:0] expAdd(input int s, input int r, input int c, input bit dec);
    int t = s + r + c;
    if (!dec) return 5'(t);
    if (t > 9) return {1'b1, 4'((t + 6) % 16)};
    return {1'b0, 4'(t)};
  endfunction

  function automatic logic [4:0] expSub(input int s, input int r, input int c, input bit dec);
    int t = s - r - c;
    if (t >= 0) return {1'b0, 4'(t)};
    if (!dec) return {1'b1, 4'((t + 32) % 16)};
    return {1'b1, 4'((t - 6 + 32) % 16)};
  endfunction

  task automatic t_idle;
    apply(3'b000, 0, 0, 1'b0);
    check("R1 idle", {carryOut, result}, 5'h00);
  endtask

  task automatic t_logic;
    for (int s = 0; s < 16; s++)
      for (int r = 0; r < 16; r++)
        for (int c = 0; c < 2; c++) begin
          apply(3'b000, s, r, 1'(c));
          check("R1 zero", {carryOut, result}, 5'h00);
          apply(3'b001, s, r, 1'(c));
          check("R2 pass s", {carryOut, result}, {1'b0, 4'(s)});
          apply(3'b010, s, r, 1'(c));
          check("R2 pass r", {carryOut, result}, {1'b0, 4'(r)});
          apply(3'b011, s, r, 1'(c));
          check("R3 xor", {carryOut, result}, {1'b0, 4'(s ^ r)});
        end
  endtask

  task automatic t_carry_ignored;
    for (int f = 0; f < 4; f++) begin
      logic [4:0] lowC;
      apply(3'(f), 11, 6, 1'b0);
      lowC = {carryOut, result};
      apply(3'(f), 11, 6, 1'b1);
      check("R8 carryIn ignored", {carryOut, result}, lowC);
      check("R8 carryOut zero", {4'b0, carryOut}, 5'h00);
    end
  endtask

  task automatic t_arith;
    for (int s = 0; s < 16; s++)
      for (int r = 0; r < 16; r++)
        for (int c = 0; c < 2; c++) begin
          apply(3'b100, s, r, 1'(c));
          check("R4 hex add", {carryOut, result}, expAdd(s, r, c, 1'b0));
          apply(3'b101, s, r, 1'(c));
          check("R5 dec add", {carryOut, result}, expAdd(s, r, c, 1'b1));
          apply(3'b110, s, r, 1'(c));
          check("R6 hex sub", {carryOut, result}, expSub(s, r, c, 1'b0));
          apply(3'b111, s, r, 1'(c));
          check("R7 dec sub", {carryOut, result}, expSub(s, r, c, 1'b1));
        end
  endtask

  task automatic t_decimal_digits;
    for (int s = 0; s < 10; s++)
      for (int r = 0; r < 10; r++)
        for (int c = 0; c < 2; c++) begin
          int sum  = s + r + c;
          int diff = s - r - c;
          apply(3'b101, s, r, 1'(c));
          check("R9 dec add digit", {carryOut, result}, {1'(sum >= 10), 4'(sum % 10)});
          apply(3'b111, s, r, 1'(c));
          check("R9 dec sub digit", {carryOut, result},
                {1'(diff < 0), 4'((diff + 10) % 10)});
        end
  endtask

  task automatic t_corners;
    apply(3'b101, 9, 9, 1'b1);
    check("R5 9+9+1", {carryOut, result}, 5'h19);
    apply(3'b101, 5, 4, 1'b0);
    check("R5 5+4 no carry", {carryOut, result}, 5'h09);
    apply(3'b111, 0, 0, 1'b1);
    check("R7 0-0-1", {carryOut, result}, 5'h19);
    apply(3'b111, 0, 9, 1'b0);
    check("R7 0-9", {carryOut, result}, 5'h11);
    apply(3'b100, 15, 15, 1'b1);
    check("R4 F+F+1", {carryOut, result}, 5'h1F);
    apply(3'b110, 0, 0, 1'b1);
    check("R6 0-0-1", {carryOut, result}, 5'h1F);
  endtask

  initial begin
    t_idle();
    t_corners();
    t_logic();
    t_carry_ignored();
    t_arith();
    t_decimal_digits();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule